// File: doc/BRIEF.md
# Linear Flash Read Cache Engine

This block lets a processor fetch 32-bit words from a serial flash device as if it were plain memory. It holds one 1024-byte line of flash contents. Any word read whose address falls inside that line is answered from local storage one cycle after the request. When a read misses, the block runs the whole flash read transaction by itself. It emits the command bytes to an SPI byte transmitter, then clocks in a full line of data and stores it. The held request is then answered from the new line.

The command is built from a 32-bit configuration word kept inside the block. That word supplies the instruction code, an optional mode byte and a dummy byte count. Two flash devices may share the window. When they are striped over two buses, each device address is half the window address. Without striping, window address bit 24 selects the second device through an upper-page output.

Top module: `lfc_top`

## Requirements
- R1: After reset the line is invalid, the configuration word holds 0x03A002EB (bit 31, linear mode, clear), `rd_ready`, `tx_valid` and `upper_page` are low.
- R2: With configuration bit 31 clear, a request is answered one cycle later with `rd_data` equal to zero and no transmit traffic.
- R3: A request whose address lies in the valid line is answered one cycle later with no transmit traffic. `rd_data` holds the four stored bytes at the word offset, with the lowest offset in bits 7:0. Address bits 1:0 are ignored.
- R4: A miss sends, in this order: configuration bits 7:0, device address bits 23:16, 15:8 and 7:0, then configuration bits 23:16 only if bit 25 is set, then as many zero bytes as configuration bits 10:8 give.
- R5: The device address is the request address with bits 9:0 cleared, shifted right by one when two buses are effective. Two buses are effective only when `dual_bus` is high and configuration bit 30 is set.
- R6: Bytes received during the command are discarded. The data phase sends zero bytes in groups of 64. A new group starts only after every byte of the previous group has returned, and exactly 1024 returned bytes are stored in arrival order.
- R7: `upper_page` is high during a fill whose device address has bit 24 set and low at every other time.
- R8: After a fill, every later word request inside the same 1024-byte window-aligned line hits.
- R9: A configuration write invalidates the line, so the next request misses even at a previously cached address.
- R10: `rd_ready` is a one-cycle pulse that follows a cycle with `rd_req` high, and a transmit byte offered while `tx_ready` is low stays offered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 25 | Byte address inside the linear window |
| rd_ready | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | 32 | Read word, little-endian |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | New configuration word |
| dual_bus | input | 1 | Two flash buses are present |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_byte | output | 8 | Byte to shift out |
| rx_valid | input | 1 | A returned byte is present |
| rx_byte | input | 8 | Byte shifted in |
| upper_page | output | 1 | Selects the second flash device |

## Verification
The bench builds the block with its default parameters: a 25-bit window, 24-bit device addresses, a 1024-byte line and 64-byte groups. These are the real sizes, so the last hit offset of 1020, the page bit at address bit 24 and the group boundaries are reached as they would be in use. Its flash model returns each byte one cycle late and can stall the transmitter. This exposes any group that starts before the previous one has fully returned. Fills cover single-bus, striped and upper-page addresses, the largest dummy count and a command without the mode byte.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } lfc_state_e;

    localparam logic [31:0] CFG_RESET       = 32'h03A0_02EB;
    localparam int          CFG_LINEAR_BIT  = 31;
    localparam int          CFG_DUAL_BIT    = 30;
    localparam int          CFG_MODE_EN_BIT = 25;
    localparam int          CFG_MODE_LSB    = 16;
    localparam int          CFG_DUMMY_LSB   = 8;
    localparam int          CFG_DUMMY_W     = 3;
    localparam int          CFG_INST_LSB    = 0;
    localparam int          CMD_LEN_W       = 5;
endpackage

// File: rtl/lfc_cmd_gen.sv
`timescale 1ns/1ps
// Byte selector for the command phase: instruction, address, mode, dummies.
module lfc_cmd_gen
    import lfc_pkg::*;
#(
    parameter int IDX_W      = 11,
    parameter int ADDR_BYTES = 3
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [31:0]             cfg,
    input  logic [8*ADDR_BYTES-1:0] dev_addr,
    output logic [7:0]              cmd_byte,
    output logic [CMD_LEN_W-1:0]    cmd_len
);
    localparam int MODE_IDX = ADDR_BYTES + 1;

    logic mode_en;
    assign mode_en = cfg[CFG_MODE_EN_BIT];

    always_comb begin
        cmd_len = CMD_LEN_W'(1 + ADDR_BYTES) + CMD_LEN_W'(mode_en)
                + CMD_LEN_W'(cfg[CFG_DUMMY_LSB +: CFG_DUMMY_W]);
        cmd_byte = 8'h00;
        if (idx == '0) begin
            cmd_byte = cfg[CFG_INST_LSB +: 8];
        end
        for (int i = 1; i <= ADDR_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                cmd_byte = dev_addr[(ADDR_BYTES - i) * 8 +: 8];
            end
        end
        if (mode_en && idx == IDX_W'(MODE_IDX)) begin
            cmd_byte = cfg[CFG_MODE_LSB +: 8];
        end
    end
endmodule

// File: rtl/lfc_line_buf.sv
`timescale 1ns/1ps
// One cache line of bytes, byte write port and 4-byte little-endian read.
module lfc_line_buf #(
    parameter  int LINE_BYTES = 1024,
    localparam int OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [OFF_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [OFF_W-1:0] raddr,
    output logic [31:0]      rdata
);
    logic [7:0] mem [LINE_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign rdata[8*b +: 8] = mem[raddr + OFF_W'(b)];
    end
endmodule

// File: rtl/lfc_burst_gate.sv
`timescale 1ns/1ps
// Data-phase pacing: groups of BURST_BYTES, a new group only once drained.
module lfc_burst_gate #(
    parameter  int LINE_BYTES  = 1024,
    parameter  int BURST_BYTES = 64,
    localparam int CNT_W       = $clog2(LINE_BYTES) + 1,
    localparam int BURST_W     = $clog2(BURST_BYTES)
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic             send_ok,
    output logic             line_last
);
    assign send_ok   = (tx_cnt < CNT_W'(LINE_BYTES))
                    && ((tx_cnt[BURST_W-1:0] != '0) || (tx_cnt == rx_cnt));
    assign line_last = (rx_cnt == CNT_W'(LINE_BYTES - 1));
endmodule

// File: rtl/lfc_top.sv
`timescale 1ns/1ps
module lfc_top
    import lfc_pkg::*;
#(
    parameter int ADDR_W      = 25,
    parameter int DEV_ADDR_W  = 24,
    parameter int LINE_BYTES  = 1024,
    parameter int BURST_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_data,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    input  logic              dual_bus,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              upper_page
);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int CNT_W      = OFF_W + 1;
    localparam int TAG_W      = ADDR_W - OFF_W;
    localparam int ADDR_BYTES = DEV_ADDR_W / 8;

    typedef struct packed {
        lfc_state_e        st;
        logic              valid;
        logic              stale;
        logic              page;
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] dev;
        logic [CNT_W-1:0]  tx_cnt;
        logic [CNT_W-1:0]  rx_cnt;
        logic [31:0]       rdata;
        logic [31:0]       cfg;
    } lfc_regs_t;

    lfc_regs_t q, d;

    logic [7:0]           cmd_byte;
    logic [CMD_LEN_W-1:0] cmd_len;
    logic                 send_ok, line_last;
    logic [31:0]          buf_rdata;
    logic                 buf_we;
    logic                 dual_eff;
    logic [ADDR_W-1:0]    aligned, dev_addr;

    lfc_cmd_gen #(.IDX_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) i_cmd_gen (
        .idx      (q.tx_cnt),
        .cfg      (q.cfg),
        .dev_addr (q.dev[8*ADDR_BYTES-1:0]),
        .cmd_byte (cmd_byte),
        .cmd_len  (cmd_len)
    );

    lfc_burst_gate #(.LINE_BYTES(LINE_BYTES), .BURST_BYTES(BURST_BYTES)) i_burst_gate (
        .tx_cnt    (q.tx_cnt),
        .rx_cnt    (q.rx_cnt),
        .send_ok   (send_ok),
        .line_last (line_last)
    );

    lfc_line_buf #(.LINE_BYTES(LINE_BYTES)) i_line_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.rx_cnt[OFF_W-1:0]),
        .wdata (rx_byte),
        .raddr ({rd_addr[OFF_W-1:2], 2'b00}),
        .rdata (buf_rdata)
    );

    assign dual_eff = dual_bus & q.cfg[CFG_DUAL_BIT];
    assign aligned  = {rd_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
    assign dev_addr = dual_eff ? (aligned >> 1) : aligned;

    assign tx_valid   = ((q.st == ST_CMD) && (q.tx_cnt < CNT_W'(cmd_len)))
                     || ((q.st == ST_DATA) && send_ok);
    assign tx_byte    = (q.st == ST_CMD) ? cmd_byte : 8'h00;
    assign rd_ready   = q.rdy;
    assign rd_data    = q.rdata;
    assign upper_page = q.page;

    always_comb begin
        d      = q;
        d.rdy  = 1'b0;
        buf_we = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (rd_req && !q.rdy) begin
                    if (!q.cfg[CFG_LINEAR_BIT]) begin
                        d.rdy   = 1'b1;
                        d.rdata = '0;
                    end else if (q.valid && (q.tag == rd_addr[ADDR_W-1:OFF_W])) begin
                        d.rdy   = 1'b1;
                        d.rdata = buf_rdata;
                    end else begin
                        d.st     = ST_CMD;
                        d.valid  = 1'b0;
                        d.stale  = 1'b0;
                        d.tag    = rd_addr[ADDR_W-1:OFF_W];
                        d.dev    = dev_addr;
                        d.page   = dev_addr[DEV_ADDR_W];
                        d.tx_cnt = '0;
                        d.rx_cnt = '0;
                    end
                end
            end
            ST_CMD: begin
                if (tx_valid && tx_ready) begin
                    d.tx_cnt = q.tx_cnt + CNT_W'(1);
                end
                if (rx_valid) begin
                    if ((q.rx_cnt + CNT_W'(1)) == CNT_W'(cmd_len)) begin
                        d.st     = ST_DATA;
                        d.tx_cnt = '0;
                        d.rx_cnt = '0;
                    end else begin
                        d.rx_cnt = q.rx_cnt + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (tx_valid && tx_ready) begin
                    d.tx_cnt = q.tx_cnt + CNT_W'(1);
                end
                if (rx_valid) begin
                    buf_we   = 1'b1;
                    d.rx_cnt = q.rx_cnt + CNT_W'(1);
                    if (line_last) begin
                        d.st    = ST_IDLE;
                        d.valid = !q.stale;
                        d.page  = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (cfg_wr) begin
            d.cfg   = cfg_wdata;
            d.valid = 1'b0;
            if ((q.st != ST_IDLE) || (d.st != ST_IDLE)) begin
                d.stale = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.cfg <= CFG_RESET;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lfc_chk.sv
`timescale 1ns/1ps
module lfc_chk
    import lfc_pkg::*;
#(
    parameter  int LINE_BYTES = 1024,
    localparam int CNT_W      = $clog2(LINE_BYTES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_byte,
    input logic             cfg_wr,
    input logic             upper_page,
    input lfc_state_e       st,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt
);
    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    // R10
    ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(rd_req));

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !cfg_wr) |=> (tx_valid && $stable(tx_byte)));

    // R7
    page_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upper_page |-> (st != ST_IDLE));

    // R8
    no_idle_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !tx_valid);

    // R6
    rx_behind_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> (rx_cnt <= tx_cnt));
endmodule

bind lfc_top lfc_chk #(.LINE_BYTES(LINE_BYTES)) i_lfc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_ready   (rd_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .cfg_wr     (cfg_wr),
    .upper_page (upper_page),
    .st         (q.st),
    .tx_cnt     (q.tx_cnt),
    .rx_cnt     (q.rx_cnt)
);

// File: tb/test_lfc_top.sv
`timescale 1ns/1ps
module test_lfc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [24:0] rd_addr = '0;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        dual_bus = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        upper_page;

    lfc_top i_lfc_top (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .dual_bus(dual_bus), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .upper_page(upper_page)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // flash model state
    logic [7:0] tx_log [0:1199];
    int  k = 0, rxk = 0, cmd_len_m = 1000, cyc = 0;
    bit  page_seen = 0, burst_bad = 0, stall_en = 0;
    logic       pend_v = 1'b0;
    logic [7:0] pend_b = '0;

    function automatic logic [7:0] flash_byte(logic [24:0] a, logic p);
        return (a[7:0] * 8'd3 + a[15:8] + a[23:16] * 8'd7) ^ (p ? 8'h80 : 8'h00);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rx_valid = 1'b0;
                pend_v   = 1'b0;
            end else begin
                logic       nv;
                logic [7:0] nb;
                nv = pend_v;
                nb = pend_b;
                cyc++;
                tx_ready = !(stall_en && (cyc % 7 == 3));
                if (upper_page) page_seen = 1;
                if (tx_valid && tx_ready) begin
                    if (k < 1200) tx_log[k] = tx_byte;
                    if (k >= cmd_len_m) begin
                        int s, r;
                        s = k - cmd_len_m;
                        r = rxk - cmd_len_m;
                        if ((s % 64 == 0) && (s != r)) burst_bad = 1;
                        pend_b = flash_byte({1'b0, tx_log[1], tx_log[2], tx_log[3]} + 25'(s),
                                            upper_page);
                    end else begin
                        pend_b = 8'h5A;
                    end
                    pend_v = 1'b1;
                    k++;
                end else begin
                    pend_v = 1'b0;
                end
                rx_valid = nv;
                rx_byte  = nb;
                if (nv) rxk++;
            end
        end
    end

    task automatic reset_model(int len);
        k = 0; rxk = 0; cmd_len_m = len; page_seen = 0; burst_bad = 0;
    endtask

    task automatic write_cfg(logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_read(logic [24:0] a, output logic [31:0] data, output int lat);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (rd_ready || lat > 20000) break;
        end
        data = rd_data;
        rd_req = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(logic [24:0] base, logic [24:0] a, logic p);
        logic [24:0] o;
        o = base + 25'({a[9:2], 2'b00});
        return {flash_byte(o + 3, p), flash_byte(o + 2, p), flash_byte(o + 1, p), flash_byte(o, p)};
    endfunction

    // miss: checks command bytes, data phase, page, and the returned word
    task automatic miss_case(string tag, logic [24:0] a, logic [31:0] cfg, logic dual,
                             logic [24:0] exp_dev, bit exp_page);
        logic [31:0] data;
        int lat, len, idx;
        bit zero_ok;
        logic [24:0] aligned, dev;
        aligned = {a[24:10], 10'd0};
        dev = (dual && cfg[30]) ? (aligned >> 1) : aligned;
        check("R5", {tag, " device address"}, 32'(dev), 32'(exp_dev));
        len = 4 + (cfg[25] ? 1 : 0) + int'(cfg[10:8]);
        reset_model(len);
        do_read(a, data, lat);
        check("R4", {tag, " instruction"}, 32'(tx_log[0]), 32'(cfg[7:0]));
        check("R4", {tag, " address bytes"}, {8'h0, tx_log[1], tx_log[2], tx_log[3]},
              {8'h0, dev[23:0]});
        idx = 4;
        if (cfg[25]) begin
            check("R4", {tag, " mode byte"}, 32'(tx_log[4]), 32'(cfg[23:16]));
            idx = 5;
        end
        zero_ok = 1;
        for (int i = idx; i < len + 1024; i++) if (tx_log[i] != 8'h00) zero_ok = 0;
        check("R4", {tag, " dummy and data bytes zero"}, 32'(zero_ok), 32'd1);
        check("R6", {tag, " total bytes sent"}, 32'(k), 32'(len + 1024));
        check("R6", {tag, " group pacing"}, 32'(burst_bad), 32'd0);
        check("R7", {tag, " page during fill"}, 32'(page_seen), 32'(exp_page));
        check("R7", {tag, " page after fill"}, 32'(upper_page), 32'd0);
        check("R3", {tag, " miss data"}, data, exp_word(dev, a, exp_page));
    endtask

    task automatic hit_case(string tag, logic [24:0] a, logic [24:0] dev, logic p);
        logic [31:0] data;
        int lat;
        reset_model(1000);
        do_read(a, data, lat);
        check("R3", {tag, " hit latency"}, 32'(lat), 32'd1);
        check("R8", {tag, " hit without traffic"}, 32'(k), 32'd0);
        check("R3", {tag, " hit data"}, data, exp_word(dev, a, p));
    endtask

    initial begin
        logic [31:0] data;
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rd_ready at reset", 32'(rd_ready), 32'd0);
        check("R1", "tx_valid at reset", 32'(tx_valid), 32'd0);
        check("R1", "upper_page at reset", 32'(upper_page), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R1: reset config leaves linear mode off
        reset_model(1000);
        do_read(25'h0001234, data, lat);
        check("R2", "linear off latency", 32'(lat), 32'd1);
        check("R2", "linear off data", data, 32'd0);
        check("R2", "linear off traffic", 32'(k), 32'd0);

        // linear on, mode byte, two dummies, single bus
        write_cfg(32'h83A0_02EB);
        miss_case("single", 25'h0001234, 32'h83A0_02EB, 1'b0, 25'h0001000, 1'b0);
        hit_case("last word", 25'h00013FC, 25'h0001000, 1'b0);
        hit_case("first word", 25'h0001000, 25'h0001000, 1'b0);
        hit_case("low bits ignored", 25'h00013FE, 25'h0001000, 1'b0);

        // R9: config write invalidates; dual present but bit 30 clear
        dual_bus = 1'b1;
        stall_en = 1;
        write_cfg(32'h8000_0003);
        miss_case("R9 refill", 25'h0001000, 32'h8000_0003, 1'b1, 25'h0001000, 1'b0);

        // R7: upper page, single bus
        miss_case("upper page", 25'h1000800, 32'h8000_0003, 1'b1, 25'h1000800, 1'b1);
        hit_case("upper page", 25'h1000A04, 25'h1000800, 1'b1);
        stall_en = 0;

        // R5: two effective buses
        write_cfg(32'hC000_0103);
        miss_case("dual", 25'h1000C00, 32'hC000_0103, 1'b1, 25'h0800600, 1'b0);
        hit_case("dual R8", 25'h1000C10, 25'h0800600, 1'b0);
        miss_case("dual top", 25'h1FFFC08, 32'hC000_0103, 1'b1, 25'h0FFFE00, 1'b0);

        // R4: largest dummy count, no mode byte
        dual_bus = 1'b0;
        write_cfg(32'h8000_07AB);
        miss_case("max dummy", 25'h0000010, 32'h8000_07AB, 1'b0, 25'h0000000, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule